// File: doc/BRIEF.md
# Transmit Descriptor Gather Sequencer

This block walks a ring of transmit descriptors kept in system memory and turns them into gather commands for a data mover. A start pulse wakes it from idle. It then reads descriptors one word at a time through a simple request/acknowledge memory port. For every descriptor that hardware still owns, it issues one fragment command with the buffer address, the fragment length and a last-fragment marker. While it does so it adds up the length of the frame being gathered.

When the last fragment of a frame has been handed out, the sequencer hands the frame back to software. It re-reads the frame's first descriptor, sets that descriptor's used bit and writes it back. It then moves its ring pointer past the frame and pulses a completion output that carries the total length. It stops and returns to idle as soon as it reads a descriptor whose used bit is already set.

The size of a descriptor in memory depends on two configuration inputs. One selects 64-bit buffer addressing and the other selects extended descriptors. Descriptor addresses are formed from a 32-bit queue base and, in 64-bit mode, a separate high-address word.

Top module: `tx_gather_seq`

## Requirements
- R1: After reset, `busy`, `memReq`, `fragValid`, `txDone` and `txAbort` are all low. The block stays idle with no memory request until `txStart` is pulsed.
- R2: A `txStart` pulse in idle starts fetching at the ring pointer. The first start after reset uses `qBase`, and later starts resume where the last finished frame left the pointer.
- R3: The descriptor layout is as follows. Word 0 holds the low 32 bits of the buffer address, and word 2 holds the high 32 bits when `cfgAddr64` is set (otherwise the high half is zero). Word 1 holds the length in bits 13:0, the last-fragment flag in bit 15, the wrap flag in bit 30 and the used flag in bit 31.
- R4: A descriptor spans 2 words, plus 2 when `cfgAddr64` is set and plus 2 more when `cfgExtDesc` is set. Consecutive descriptors are 4 times that word count bytes apart. Every memory address carries `qBaseHigh` in bits 63:32 when `cfgAddr64` is set, and zero there otherwise.
- R5: Reading a descriptor whose used flag is set returns the block to idle. A frame left partly gathered raises no outcome pulse, and the ring pointer stays at that frame's first descriptor.
- R6: Each accepted descriptor produces exactly one single-cycle `fragValid` carrying the buffer address, the length and the descriptor's last flag, in ring order.
- R7: A descriptor whose full buffer address is zero, or whose length is zero, pulses `txAbort` and returns the block to idle. The ring pointer is left unchanged, so a later start retries the whole frame.
- R8: On a last descriptor, word 1 of the frame's first descriptor is read back and rewritten with bit 31 set and all other bits unchanged. Then `txDone` pulses with `txLen` equal to the sum of the frame's fragment lengths.
- R9: After a frame completes, the ring pointer becomes `qBase` if the last descriptor had wrap set, and otherwise that descriptor's address plus the stride. Fetching continues from there without a new start.
- R10: Inside a frame, a non-last descriptor with wrap set makes the next fragment come from `qBase`, and otherwise from the next stride.
- R11: A fragment that would take the frame total above 2048 bytes is not issued, and neither is any later fragment of that frame. The walk still runs to the last descriptor and marks the first descriptor used, but `txAbort` pulses instead of `txDone`. A total of exactly 2048 is accepted.
- R12: A `txStart` pulse while the block is busy is ignored and does not cause a second pass once the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txStart | input | 1 | Start pulse, accepted only when idle |
| cfgAddr64 | input | 1 | 64-bit buffer addressing enable |
| cfgExtDesc | input | 1 | Extended descriptor enable (adds two words) |
| qBase | input | 32 | Ring base address, low word |
| qBaseHigh | input | 32 | High address word used in 64-bit mode |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Request is a write |
| memAddr | output | 64 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request accepted; read data valid in this cycle |
| memRdata | input | 32 | Read data |
| fragValid | output | 1 | Fragment command strobe |
| fragAddr | output | 64 | Fragment buffer address |
| fragLen | output | LEN_W | Fragment length in bytes |
| fragLast | output | 1 | Fragment ends the frame |
| txDone | output | 1 | Frame completed pulse |
| txAbort | output | 1 | Frame aborted or dropped pulse |
| txLen | output | TOT_W | Frame length, valid with `txDone` |
| busy | output | 1 | Sequencer is walking the ring |

## Verification
The hardest situations to reach are those where one frame's walk is cut short or turned aside partway. Examples are a used descriptor met inside a frame, a zero-length fragment after an accepted one, a drop that begins on a middle fragment, and a wrap on a non-last descriptor. In each case the ring pointer must survive correctly for the next start. The bench reaches these by writing specific ring layouts into its own memory model and issuing starts back to back without a reset. A retried frame, or one that continues after a wrap, then shows any pointer error directly in the fragment addresses that follow. Memory latency and the addressing mode change between runs, so descriptor strides of 8, 16 and 24 bytes are all walked.

// File: rtl/tx_gather_pkg.sv
package tx_gather_pkg;

  // descriptor word-1 flag positions (decoded by software as well)
  localparam int USED_BIT = 31;
  localparam int WRAP_BIT = 30;
  localparam int LAST_BIT = 15;
  localparam int WORD_W   = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_W0,
    ST_RD_W1,
    ST_RD_W2,
    ST_EVAL,
    ST_RD_FIRST,
    ST_WR_FIRST
  } seqState_t;

  typedef enum logic [1:0] {
    SEL_W0,
    SEL_W1,
    SEL_W2,
    SEL_FIRST
  } addrSel_t;

  typedef struct packed {
    logic     loadStart;
    logic     capW0;
    logic     capW1;
    logic     capW2;
    logic     capFirst;
    logic     takeFrag;
    logic     stepFetch;
    logic     finishPkt;
    logic     abortPkt;
    addrSel_t addrSel;
  } ctrlStrobe_t;

  typedef struct packed {
    logic used;
    logic invalid;
    logic last;
  } descFlags_t;

endpackage

// File: rtl/tx_gather_ctrl.sv
module tx_gather_ctrl
  import tx_gather_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txStart,
  input  logic        cfgAddr64,
  input  logic        memAck,
  input  descFlags_t  flags,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        busy
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    strobe.addrSel = SEL_W0;
    memReq         = 1'b0;
    memWe          = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (txStart) begin
          strobe.loadStart = 1'b1;
          stateNext        = ST_RD_W0;
        end
      end
      ST_RD_W0: begin
        memReq         = 1'b1;
        strobe.addrSel = SEL_W0;
        if (memAck) begin
          strobe.capW0 = 1'b1;
          stateNext    = ST_RD_W1;
        end
      end
      ST_RD_W1: begin
        memReq         = 1'b1;
        strobe.addrSel = SEL_W1;
        if (memAck) begin
          strobe.capW1 = 1'b1;
          stateNext    = cfgAddr64 ? ST_RD_W2 : ST_EVAL;
        end
      end
      ST_RD_W2: begin
        memReq         = 1'b1;
        strobe.addrSel = SEL_W2;
        if (memAck) begin
          strobe.capW2 = 1'b1;
          stateNext    = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (flags.used) begin
          stateNext = ST_IDLE;
        end else if (flags.invalid) begin
          strobe.abortPkt = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          strobe.takeFrag = 1'b1;
          if (flags.last) begin
            stateNext = ST_RD_FIRST;
          end else begin
            strobe.stepFetch = 1'b1;
            stateNext        = ST_RD_W0;
          end
        end
      end
      ST_RD_FIRST: begin
        memReq         = 1'b1;
        strobe.addrSel = SEL_FIRST;
        if (memAck) begin
          strobe.capFirst = 1'b1;
          stateNext       = ST_WR_FIRST;
        end
      end
      ST_WR_FIRST: begin
        memReq         = 1'b1;
        memWe          = 1'b1;
        strobe.addrSel = SEL_FIRST;
        if (memAck) begin
          strobe.finishPkt = 1'b1;
          stateNext        = ST_RD_W0;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/tx_gather_dpath.sv
module tx_gather_dpath
  import tx_gather_pkg::*;
#(
  parameter int LEN_W      = 14,
  parameter int FRAME_MAX  = 2048,
  parameter int BASE_WORDS = 2,
  parameter int EXT_WORDS  = 2,
  parameter int TOT_W      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              cfgAddr64,
  input  logic              cfgExtDesc,
  input  logic [31:0]       qBase,
  input  logic [31:0]       qBaseHigh,
  input  logic [31:0]       memRdata,
  output descFlags_t        flags,
  output logic [63:0]       memAddr,
  output logic [31:0]       memWdata,
  output logic              fragValid,
  output logic [63:0]       fragAddr,
  output logic [LEN_W-1:0]  fragLen,
  output logic              fragLast,
  output logic              txDone,
  output logic              txAbort,
  output logic [TOT_W-1:0]  txLen
);

  localparam int SUM_W       = ((TOT_W > LEN_W) ? TOT_W : LEN_W) + 1;
  localparam int STRIDE_BASE = 4 * BASE_WORDS;
  localparam int STRIDE_EXT  = 4 * EXT_WORDS;

  logic [31:0]      ringPtr, fetchPtr;
  logic             ringLoaded;
  logic [31:0]      descLo, descHi, firstW1;
  logic             descUsed, descWrap, descLast;
  logic [LEN_W-1:0] descLen;
  logic [TOT_W-1:0] total;
  logic             dropping;

  logic [31:0]      strideBytes, nextFetch, lowAddr, startPtr;
  logic [63:0]      bufAddr;
  logic [SUM_W-1:0] sumWide;
  logic             fits;

  always_comb begin
    strideBytes = 32'(STRIDE_BASE);
    if (cfgAddr64)  strideBytes = strideBytes + 32'(STRIDE_EXT);
    if (cfgExtDesc) strideBytes = strideBytes + 32'(STRIDE_EXT);
  end

  assign bufAddr   = {(cfgAddr64 ? descHi : 32'd0), descLo};
  assign nextFetch = descWrap ? qBase : (fetchPtr + strideBytes);
  assign sumWide   = SUM_W'(total) + SUM_W'(descLen);
  assign fits      = !dropping && (sumWide <= SUM_W'(FRAME_MAX));
  assign startPtr  = ringLoaded ? ringPtr : qBase;

  assign flags.used    = descUsed;
  assign flags.invalid = (bufAddr == 64'd0) || (descLen == '0);
  assign flags.last    = descLast;

  always_comb begin
    unique case (strobe.addrSel)
      SEL_W0:    lowAddr = fetchPtr;
      SEL_W1:    lowAddr = fetchPtr + 32'd4;
      SEL_W2:    lowAddr = fetchPtr + 32'd8;
      SEL_FIRST: lowAddr = ringPtr + 32'd4;
      default:   lowAddr = fetchPtr;
    endcase
  end

  assign memAddr  = {(cfgAddr64 ? qBaseHigh : 32'd0), lowAddr};
  assign memWdata = firstW1 | (32'd1 << USED_BIT);

  // descriptor capture and ring walk
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringPtr    <= '0;
      fetchPtr   <= '0;
      ringLoaded <= 1'b0;
      descLo     <= '0;
      descHi     <= '0;
      descUsed   <= 1'b0;
      descWrap   <= 1'b0;
      descLast   <= 1'b0;
      descLen    <= '0;
      firstW1    <= '0;
      total      <= '0;
      dropping   <= 1'b0;
    end else begin
      if (strobe.loadStart) begin
        ringPtr    <= startPtr;
        fetchPtr   <= startPtr;
        ringLoaded <= 1'b1;
        total      <= '0;
        dropping   <= 1'b0;
      end
      if (strobe.capW0) descLo <= memRdata;
      if (strobe.capW1) begin
        descUsed <= memRdata[USED_BIT];
        descWrap <= memRdata[WRAP_BIT];
        descLast <= memRdata[LAST_BIT];
        descLen  <= memRdata[LEN_W-1:0];
      end
      if (strobe.capW2)    descHi  <= memRdata;
      if (strobe.capFirst) firstW1 <= memRdata;
      if (strobe.takeFrag) begin
        if (fits) total    <= TOT_W'(sumWide);
        else      dropping <= 1'b1;
      end
      if (strobe.stepFetch) fetchPtr <= nextFetch;
      if (strobe.finishPkt) begin
        ringPtr  <= nextFetch;
        fetchPtr <= nextFetch;
        total    <= '0;
        dropping <= 1'b0;
      end
    end
  end

  // fragment command and frame outcome
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fragValid <= 1'b0;
      fragAddr  <= '0;
      fragLen   <= '0;
      fragLast  <= 1'b0;
      txDone    <= 1'b0;
      txAbort   <= 1'b0;
      txLen     <= '0;
    end else begin
      fragValid <= 1'b0;
      txDone    <= 1'b0;
      txAbort   <= 1'b0;
      if (strobe.takeFrag && fits) begin
        fragValid <= 1'b1;
        fragAddr  <= bufAddr;
        fragLen   <= descLen;
        fragLast  <= descLast;
      end
      if (strobe.finishPkt) begin
        txLen <= total;
        if (dropping) txAbort <= 1'b1;
        else          txDone  <= 1'b1;
      end
      if (strobe.abortPkt) begin
        txLen   <= '0;
        txAbort <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tx_gather_seq.sv
module tx_gather_seq
  import tx_gather_pkg::*;
#(
  parameter int  LEN_W      = 14,
  parameter int  FRAME_MAX  = 2048,
  parameter int  BASE_WORDS = 2,
  parameter int  EXT_WORDS  = 2,
  localparam int TOT_W      = $clog2(FRAME_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txStart,
  input  logic             cfgAddr64,
  input  logic             cfgExtDesc,
  input  logic [31:0]      qBase,
  input  logic [31:0]      qBaseHigh,
  output logic             memReq,
  output logic             memWe,
  output logic [63:0]      memAddr,
  output logic [31:0]      memWdata,
  input  logic             memAck,
  input  logic [31:0]      memRdata,
  output logic             fragValid,
  output logic [63:0]      fragAddr,
  output logic [LEN_W-1:0] fragLen,
  output logic             fragLast,
  output logic             txDone,
  output logic             txAbort,
  output logic [TOT_W-1:0] txLen,
  output logic             busy
);

  ctrlStrobe_t strobe;
  descFlags_t  flags;

  tx_gather_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txStart   (txStart),
    .cfgAddr64 (cfgAddr64),
    .memAck    (memAck),
    .flags     (flags),
    .strobe    (strobe),
    .memReq    (memReq),
    .memWe     (memWe),
    .busy      (busy)
  );

  tx_gather_dpath #(
    .LEN_W      (LEN_W),
    .FRAME_MAX  (FRAME_MAX),
    .BASE_WORDS (BASE_WORDS),
    .EXT_WORDS  (EXT_WORDS),
    .TOT_W      (TOT_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgAddr64  (cfgAddr64),
    .cfgExtDesc (cfgExtDesc),
    .qBase      (qBase),
    .qBaseHigh  (qBaseHigh),
    .memRdata   (memRdata),
    .flags      (flags),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .fragValid  (fragValid),
    .fragAddr   (fragAddr),
    .fragLen    (fragLen),
    .fragLast   (fragLast),
    .txDone     (txDone),
    .txAbort    (txAbort),
    .txLen      (txLen)
  );

endmodule

// File: rtl/tx_gather_chk.sv
module tx_gather_chk #(
  parameter int  LEN_W     = 14,
  parameter int  FRAME_MAX = 2048,
  localparam int TOT_W     = $clog2(FRAME_MAX + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             txStart,
  input logic             cfgAddr64,
  input logic             memReq,
  input logic             memWe,
  input logic [63:0]      memAddr,
  input logic             wbUsedBit,
  input logic             memAck,
  input logic             fragValid,
  input logic [63:0]      fragAddr,
  input logic [LEN_W-1:0] fragLen,
  input logic             txDone,
  input logic             txAbort,
  input logic [TOT_W-1:0] txLen,
  input logic             busy
);

  // R1: no memory traffic or fragment while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !fragValid));

  // R2: leaving idle needs a start pulse
  p_start_needed_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(txStart));

  // R4: a pending request keeps its address and direction
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R4: high address half is zero outside 64-bit mode, words are aligned
  p_high_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !cfgAddr64) |-> (memAddr[63:32] == 32'd0 && memAddr[1:0] == 2'b00));

  // R7: an issued fragment never has a zero address or length
  p_frag_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    fragValid |-> (fragLen != '0 && fragAddr != 64'd0));

  // R8: write-back always carries the used flag
  p_writeback_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> wbUsedBit);

  // R11: one outcome at a time, and completed lengths fit the frame buffer
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(txDone && txAbort));

  p_len_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (txLen != '0 && txLen <= TOT_W'(FRAME_MAX)));

endmodule

bind tx_gather_seq tx_gather_chk #(
  .LEN_W     (LEN_W),
  .FRAME_MAX (FRAME_MAX)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txStart   (txStart),
  .cfgAddr64 (cfgAddr64),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .wbUsedBit (memWdata[31]),
  .memAck    (memAck),
  .fragValid (fragValid),
  .fragAddr  (fragAddr),
  .fragLen   (fragLen),
  .txDone    (txDone),
  .txAbort   (txAbort),
  .txLen     (txLen),
  .busy      (busy)
);

// File: tb/tx_gather_seq_test.sv
module tx_gather_seq_test;

  localparam int LEN_W = 14;
  localparam int FMAX  = 2048;

  logic        clk = 1'b0, rstN = 1'b0, txStart = 1'b0;
  logic        cfgAddr64 = 1'b0, cfgExtDesc = 1'b0;
  logic [31:0] qBase = 32'h100, qBaseHigh = 32'h0;
  logic        memReq, memWe, memAck = 1'b0;
  logic [63:0] memAddr;
  logic [31:0] memWdata, memRdata = 32'h0;
  logic        fragValid, fragLast, txDone, txAbort, busy;
  logic [63:0] fragAddr;
  logic [LEN_W-1:0] fragLen;
  logic [11:0] txLen;

  always #4 clk = ~clk;

  tx_gather_seq uut (
    .clk(clk), .rstN(rstN), .txStart(txStart), .cfgAddr64(cfgAddr64),
    .cfgExtDesc(cfgExtDesc), .qBase(qBase), .qBaseHigh(qBaseHigh),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .fragValid(fragValid),
    .fragAddr(fragAddr), .fragLen(fragLen), .fragLast(fragLast),
    .txDone(txDone), .txAbort(txAbort), .txLen(txLen), .busy(busy)
  );

  int checks = 0, errors = 0, cycles = 0;
  int lat = 0, latCnt = 0;
  logic [31:0] mem [0:255];
  logic [31:0] mm  [0:255];
  logic [78:0] fragQ [$];
  logic [12:0] doneQ [$];
  logic [31:0] mRing = 32'h0;
  bit          mInit = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] w1f(bit used, bit wrap, bit last, int len);
    logic [31:0] w;
    w = 32'(len) & 32'h3FFF;
    w[31] = used; w[30] = wrap; w[15] = last;
    return w;
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
    mem[a[9:2]]       = w0;
    mem[a[9:2] + 8'd1] = w1;
    mem[a[9:2] + 8'd2] = w2;
  endtask

  task automatic fill_mem();
    foreach (mem[i]) mem[i] = 32'h8000_0000;
  endtask

  function automatic logic [31:0] mrd(logic [31:0] a);
    return mm[a[9:2]];
  endfunction

  // behavioural ring walk producing the expected event streams
  task automatic model_run();
    logic [31:0] ptr, fetch, w0, w1, w2, stride;
    logic [63:0] bufA;
    int len, total;
    bit drop;
    stride = 32'(4 * (2 + (cfgAddr64 ? 2 : 0) + (cfgExtDesc ? 2 : 0)));
    if (!mInit) begin mRing = qBase; mInit = 1'b1; end
    ptr = mRing; fetch = ptr; total = 0; drop = 1'b0;
    for (int guard = 0; guard < 64; guard++) begin
      w0 = mrd(fetch); w1 = mrd(fetch + 4);
      w2 = cfgAddr64 ? mrd(fetch + 8) : 32'h0;
      if (w1[31]) return;
      bufA = {w2, w0}; len = int'(w1[13:0]);
      if (bufA == 64'd0 || len == 0) begin doneQ.push_back({1'b1, 12'd0}); return; end
      if (!drop && total + len <= FMAX) begin
        fragQ.push_back({bufA, 14'(len), w1[15]});
        total += len;
      end else drop = 1'b1;
      if (w1[15]) begin
        mm[(ptr + 4) >> 2] = mrd(ptr + 4) | 32'h8000_0000;
        doneQ.push_back(drop ? {1'b1, 12'd0} : {1'b0, 12'(total)});
        ptr = w1[30] ? qBase : fetch + stride;
        mRing = ptr; fetch = ptr; total = 0; drop = 1'b0;
      end else begin
        fetch = w1[30] ? qBase : fetch + stride;
      end
    end
  endtask

  // memory responder, per-clock comparison and watchdog
  always @(negedge clk) begin
    logic [78:0] ef;
    logic [12:0] ed;
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rstN) begin
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (latCnt >= lat) begin
          chk(memAddr[63:32] == (cfgAddr64 ? qBaseHigh : 32'h0), "R4 high address",
              80'(memAddr[63:32]), 80'(cfgAddr64 ? qBaseHigh : 32'h0));
          if (memWe) mem[memAddr[9:2]] = memWdata;
          else       memRdata = mem[memAddr[9:2]];
          memAck = 1'b1; latCnt = 0;
        end else latCnt++;
      end
      if (fragValid) begin
        if (fragQ.size() == 0) chk(1'b0, "R6 unexpected fragment", 80'({fragAddr, fragLen, fragLast}), 80'(0));
        else begin
          ef = fragQ.pop_front();
          chk({fragAddr, fragLen, fragLast} == ef, "R6 fragment", 80'({fragAddr, fragLen, fragLast}), 80'(ef));
        end
      end
      if (txDone || txAbort) begin
        chk(!(txDone && txAbort), "R11 single outcome", 80'({txDone, txAbort}), 80'(1));
        if (doneQ.size() == 0) chk(1'b0, "R8 unexpected outcome", 80'({txAbort, txLen}), 80'(0));
        else begin
          ed = doneQ.pop_front();
          chk({txAbort, (txDone ? txLen : 12'd0)} == ed, "R8/R11 frame outcome",
              80'({txAbort, (txDone ? txLen : 12'd0)}), 80'(ed));
        end
      end
    end
  end

  task automatic run_case(input string name, input int latency, input bit extraStart);
    int waitc;
    bit memOk, stayIdle;
    lat = latency;
    foreach (mem[i]) mm[i] = mem[i];
    model_run();
    @(negedge clk); txStart = 1'b1;
    @(negedge clk); txStart = 1'b0;
    if (extraStart) begin
      repeat (3) @(negedge clk);
      txStart = 1'b1;
      @(negedge clk); txStart = 1'b0;
    end
    waitc = 0;
    while (busy && waitc < 5000) begin @(negedge clk); waitc++; end
    stayIdle = 1'b1;
    repeat (20) begin @(negedge clk); if (busy) stayIdle = 1'b0; end
    chk(stayIdle, $sformatf("R5 R12 idle after %s", name), 80'(busy), 80'(0));
    chk(fragQ.size() == 0, $sformatf("R6 fragments outstanding %s", name), 80'(fragQ.size()), 80'(0));
    chk(doneQ.size() == 0, $sformatf("R8 outcomes outstanding %s", name), 80'(doneQ.size()), 80'(0));
    memOk = 1'b1;
    foreach (mem[i]) if (mem[i] !== mm[i]) memOk = 1'b0;
    chk(memOk, $sformatf("R8 ring image %s", name), 80'(memOk), 80'(1));
    fragQ.delete(); doneQ.delete();
  endtask

  initial begin
    fill_mem();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !memReq && !fragValid && !txDone && !txAbort, "R1 reset state",
        80'({busy, memReq, fragValid, txDone, txAbort}), 80'(0));
    repeat (10) @(negedge clk);
    chk(!busy && !memReq, "R1 idle without start", 80'({busy, memReq}), 80'(0));

    // R2 R3 R6 R8: two frames from the queue base, stride 8
    put(32'h100, 32'h1000, w1f(0, 0, 1, 100), 32'h8000_0000);
    put(32'h108, 32'h2000, w1f(0, 0, 0, 60),  32'h8000_0000);
    put(32'h110, 32'h3000, w1f(0, 0, 1, 40),  32'h8000_0000);
    run_case("basic", 0, 1'b0);

    // R2 R9 resume from the ring pointer
    put(32'h118, 32'h4000, w1f(0, 0, 1, 1500), 32'h8000_0000);
    run_case("resume", 2, 1'b0);

    // R10 wrap inside a frame, R9 wrap on last
    put(32'h120, 32'h5000, w1f(0, 1, 0, 10), 32'h8000_0000);
    put(32'h100, 32'h6000, w1f(0, 1, 1, 20), 32'h8000_0000);
    run_case("wrap", 1, 1'b0);

    // R7 zero length mid-frame, then retry of the same frame
    fill_mem();
    put(32'h100, 32'h7000, w1f(0, 0, 0, 30), 32'h8000_0000);
    put(32'h108, 32'h7100, w1f(0, 0, 1, 0),  32'h8000_0000);
    run_case("zero length", 0, 1'b0);
    put(32'h108, 32'h7100, w1f(0, 0, 1, 50), 32'h8000_0000);
    run_case("retry", 1, 1'b0);

    // R7 zero buffer address
    put(32'h110, 32'h0, w1f(0, 0, 1, 5), 32'h8000_0000);
    run_case("zero address", 0, 1'b0);

    // R11 oversize drop, then exact 2048 boundary
    put(32'h110, 32'h8000, w1f(0, 0, 0, 1500), 32'h8000_0000);
    put(32'h118, 32'h9000, w1f(0, 0, 0, 1000), 32'h8000_0000);
    put(32'h120, 32'hA000, w1f(0, 0, 1, 100),  32'h8000_0000);
    put(32'h128, 32'hB000, w1f(0, 0, 1, 2048), 32'h8000_0000);
    run_case("oversize", 2, 1'b0);

    // R5 used descriptor inside a frame, then completion with R12 extra start
    put(32'h130, 32'hC000, w1f(0, 0, 0, 70), 32'h8000_0000);
    run_case("partial", 0, 1'b0);
    put(32'h138, 32'hC100, w1f(0, 0, 1, 30), 32'h8000_0000);
    run_case("complete", 3, 1'b1);

    // R4 64-bit with extended descriptors: stride 24, high address words
    fill_mem();
    cfgAddr64 = 1'b1; cfgExtDesc = 1'b1; qBaseHigh = 32'h0000_00A5;
    put(32'h140, 32'h0000_0100, w1f(0, 0, 0, 64), 32'h1);
    put(32'h158, 32'h0000_0200, w1f(0, 1, 1, 36), 32'h2);
    put(32'h100, 32'h0000_0000, w1f(0, 0, 1, 8),  32'h7);
    run_case("addr64 ext", 1, 1'b0);

    // R4 extended only in 32-bit mode: stride 16, word 2 ignored (R3)
    fill_mem();
    cfgAddr64 = 1'b0; cfgExtDesc = 1'b1;
    put(32'h118, 32'hD000, w1f(0, 0, 0, 12), 32'h1234);
    put(32'h128, 32'hE000, w1f(0, 0, 1, 4),  32'h8000_0000);
    run_case("ext only", 0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule